// File: doc/BRIEF.md
# Processor Presence Bitmap Port with Hot-Add Event

This block keeps a presence bitmap with one bit for every processor slot. A bit's position in the map equals the APIC ID of its processor. Firmware reads the map one byte at a time through an I/O window. The default of 256 slots gives a 32-byte window. When the platform hot-adds a processor, it pulses `hp_add_valid` with that processor's ID. The block then sets the matching bit. If the bit was clear before, the block also latches bit 2 of a small general-purpose event (GPE) status register. The system control interrupt output `sci` is raised while that status bit and its enable bit are both set. The firmware event handler then scans the map to find the new processor.

Software cannot write the map; bits are only ever set, because processors cannot be removed. The map's first 32-bit word has one write function: a 32-bit write of zero to it switches the platform to the newer selector-based hotplug interface. The block reports this through the sticky flag `new_if_sel`, which only a reset clears. The GPE latch has its own chip select. It holds a write-1-to-clear status byte at offset 0 and an enable byte at offset 1, and only bit 2 is implemented in each.

Top module: `cpu_presence_port`

## Requirements
- R1: After reset every map bit is 0, the GPE status and enable bits are 0, and `sci` and `new_if_sel` are 0.
- R2: A pulse on `hp_add_valid` sets the map bit for `hp_add_id`. That bit reads as bit (ID mod 8) of map byte offset (ID / 8).
- R3: Map bits never go from 1 to 0 while out of reset. No write of any size, value or offset through `map_cs` changes the map.
- R4: A hot-add whose ID was not yet present sets GPE status bit 2, which reads as 0x04 at GPE offset 0. A hot-add for an ID already present leaves the status unchanged.
- R5: `sci` is 1 exactly when GPE status bit 2 and GPE enable bit 2 are both 1.
- R6: A write through `gpe_cs` to offset 0 with data bit 2 set clears status bit 2. The same write with data bit 2 clear leaves the bit unchanged. When a clear and a new hot-add event occur in the same cycle, the status ends up set.
- R7: A write through `gpe_cs` to offset 1 stores data bit 2 as enable bit 2, which reads back as 0x04. All other GPE bits read as 0.
- R8: A 32-bit write (`io_dword`=1) through `map_cs` of the value 0 to a byte offset in 0..3 sets `new_if_sel`. Once set, it stays at 1 until reset.
- R9: None of these writes sets `new_if_sel`: a nonzero value, a byte-sized write (`io_dword`=0), a write to map offset 4 or above, or a write through `gpe_cs`.
- R10: Read data is registered. `io_rd_data` takes the addressed byte at the clock edge where `io_rd` is 1. It holds that value while `io_rd` is 0. A read with neither chip select returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hp_add_valid | input | 1 | One-cycle hot-add request |
| hp_add_id | input | 8 | APIC ID of the processor being added |
| map_cs | input | 1 | Selects the presence map window |
| gpe_cs | input | 1 | Selects the GPE status/enable latch |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_dword | input | 1 | 1 for a 32-bit write, 0 for a byte write |
| io_addr | input | 5 | Byte offset within the selected window |
| io_wr_data | input | 32 | Write data |
| io_rd_data | output | 8 | Registered read data |
| sci | output | 1 | Interrupt request: status bit 2 AND enable bit 2 |
| new_if_sel | output | 1 | Sticky flag selecting the newer hotplug interface |

## Verification
The assertions check on every cycle that map bits never clear and that a hot-add always leaves its bit set. They also check that a fresh hot-add always latches the event status and that a clear with no competing event empties it. Finally, they check that `new_if_sel` never falls and that nonzero or misdirected writes never raise it. The bench scenarios show the rest. These are the byte and bit placement of IDs in the map and the suppression of repeated hot-add events. They also cover how `sci` follows the enable bit, and which exact write shape performs the mode switch. The last of these depends on several input fields together, so it needs chosen stimulus.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;
  // GPE bit position that carries the processor hot-add event
  localparam int unsigned GPE_HP_BIT = 2;
  // GPE latch register offsets (io_addr[0])
  typedef enum logic {
    GPE_OFS_STATUS = 1'b0,
    GPE_OFS_ENABLE = 1'b1
  } gpe_ofs_e;
  // write access sizes
  typedef enum logic {
    ACC_BYTE  = 1'b0,
    ACC_DWORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
  parameter int unsigned NUM_SLOTS = 256,
  localparam int unsigned ID_W     = $clog2(NUM_SLOTS),
  localparam int unsigned NBYTES   = NUM_SLOTS / 8,
  localparam int unsigned ADDR_W   = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_valid,
  input  logic [ID_W-1:0]   add_id,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              add_is_new
);
  logic [NUM_SLOTS-1:0] present_q;
  logic [NUM_SLOTS-1:0] present_d;
  logic                 present_en;

  // next state: bits are only ever set
  always_comb begin
    present_d  = present_q;
    present_en = add_valid;
    if (add_valid) present_d[add_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          present_q <= '0;
    else if (present_en) present_q <= present_d;
  end

  assign add_is_new = add_valid && !present_q[add_id];

  // byte view of the map
  logic [7:0] byte_view [NBYTES];
  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign byte_view[g] = present_q[g*8 +: 8];
  end
  assign rd_byte = byte_view[rd_addr];

  p_never_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((present_q & $past(present_q)) == $past(present_q)));

  p_add_sets_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid |=> present_q[$past(add_id)]);
endmodule

// File: rtl/cpu_mode_switch.sv
module cpu_mode_switch #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_cs,
  input  logic              io_wr,
  input  logic              io_dword,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [31:0]       io_wr_data,
  output logic              new_if_sel
);
  import cpu_presence_pkg::*;

  logic new_if_q, new_if_d, zero_hit;

  assign zero_hit = map_cs && io_wr && (io_dword == ACC_DWORD) &&
                    (io_addr[ADDR_W-1:2] == '0) && (io_wr_data == 32'd0);

  always_comb begin
    new_if_d = new_if_q | zero_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        new_if_q <= 1'b0;
    else if (zero_hit) new_if_q <= new_if_d;
  end

  assign new_if_sel = new_if_q;

  p_sticky_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    new_if_q |=> new_if_q);

  p_nonzero_no_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!new_if_q && io_wr && (io_wr_data != 32'd0)) |=> !new_if_q);

  p_byte_no_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!new_if_q && io_wr && !io_dword) |=> !new_if_q);
endmodule

// File: rtl/cpu_gpe_latch.sv
module cpu_gpe_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_set,
  input  logic        gpe_cs,
  input  logic        io_wr,
  input  logic        io_ofs,
  input  logic [31:0] io_wr_data,
  output logic [7:0]  status_byte,
  output logic [7:0]  enable_byte,
  output logic        sci
);
  import cpu_presence_pkg::*;

  logic sts_q, sts_d, sts_en;
  logic ena_q, ena_d, ena_en;
  logic w1c;

  assign w1c    = gpe_cs && io_wr && (io_ofs == GPE_OFS_STATUS) && io_wr_data[GPE_HP_BIT];
  assign ena_en = gpe_cs && io_wr && (io_ofs == GPE_OFS_ENABLE);
  assign sts_en = w1c || evt_set;

  // a new event wins over a simultaneous clear
  always_comb begin
    sts_d = sts_q;
    if (w1c)     sts_d = 1'b0;
    if (evt_set) sts_d = 1'b1;
    ena_d = io_wr_data[GPE_HP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      ena_q <= 1'b0;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (ena_en) ena_q <= ena_d;
    end
  end

  assign status_byte = 8'(sts_q) << GPE_HP_BIT;
  assign enable_byte = 8'(ena_q) << GPE_HP_BIT;
  assign sci         = sts_q & ena_q;

  p_event_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> sts_q);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !evt_set) |=> !sts_q);
endmodule

// File: rtl/cpu_presence_port.sv
module cpu_presence_port #(
  parameter int unsigned NUM_SLOTS = 256,
  localparam int unsigned ID_W     = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W   = $clog2(NUM_SLOTS / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_add_valid,
  input  logic [ID_W-1:0]   hp_add_id,
  input  logic              map_cs,
  input  logic              gpe_cs,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_dword,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [31:0]       io_wr_data,
  output logic [7:0]        io_rd_data,
  output logic              sci,
  output logic              new_if_sel
);
  // asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [7:0] map_byte, sts_byte, ena_byte;
  logic       add_is_new;

  cpu_presence_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .add_valid (hp_add_valid),
    .add_id    (hp_add_id),
    .rd_addr   (io_addr),
    .rd_byte   (map_byte),
    .add_is_new(add_is_new)
  );

  cpu_mode_switch #(.ADDR_W(ADDR_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .map_cs    (map_cs),
    .io_wr     (io_wr),
    .io_dword  (io_dword),
    .io_addr   (io_addr),
    .io_wr_data(io_wr_data),
    .new_if_sel(new_if_sel)
  );

  cpu_gpe_latch u_gpe (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .evt_set    (add_is_new),
    .gpe_cs     (gpe_cs),
    .io_wr      (io_wr),
    .io_ofs     (io_addr[0]),
    .io_wr_data (io_wr_data),
    .status_byte(sts_byte),
    .enable_byte(ena_byte),
    .sci        (sci)
  );

  // registered read path
  logic [7:0] rd_q, rd_d;
  always_comb begin
    if (map_cs)      rd_d = map_byte;
    else if (gpe_cs) rd_d = io_addr[0] ? ena_byte : sts_byte;
    else             rd_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q)  rd_q <= 8'h00;
    else if (io_rd) rd_q <= rd_d;
  end

  assign io_rd_data = rd_q;

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !io_rd |=> $stable(io_rd_data));
endmodule

// File: tb/sim_cpu_presence_port.sv
module sim_cpu_presence_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hp_add_valid;
  logic [7:0]  hp_add_id;
  logic        map_cs, gpe_cs, io_rd, io_wr, io_dword;
  logic [4:0]  io_addr;
  logic [31:0] io_wr_data;
  logic [7:0]  io_rd_data;
  logic        sci, new_if_sel;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  cpu_presence_port u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    hp_add_valid = 0; hp_add_id = 0; map_cs = 0; gpe_cs = 0;
    io_rd = 0; io_wr = 0; io_dword = 0; io_addr = 0; io_wr_data = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input bit to_map, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    map_cs = to_map; gpe_cs = !to_map; io_rd = 1; io_addr = a;
    @(negedge clk);
    idle();
    d = io_rd_data;
  endtask

  task automatic wr(input bit to_map, input bit to_gpe, input logic [4:0] a,
                    input bit dw, input logic [31:0] v);
    @(negedge clk);
    map_cs = to_map; gpe_cs = to_gpe; io_wr = 1; io_dword = dw;
    io_addr = a; io_wr_data = v;
    @(negedge clk);
    idle();
  endtask

  task automatic hot_add(input logic [7:0] id);
    @(negedge clk);
    hp_add_valid = 1; hp_add_id = id;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1, 5'd0, d);  check("R1 map byte0", d, 8'h00);
    rd(1, 5'd31, d); check("R1 map byte31", d, 8'h00);
    rd(0, 5'd0, d);  check("R1 gpe status", d, 8'h00);
    rd(0, 5'd1, d);  check("R1 gpe enable", d, 8'h00);
    check("R1 sci", sci, 0);
    check("R1 new_if_sel", new_if_sel, 0);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(0, 1, 5'd1, 0, 32'hFF);
    rd(0, 5'd1, d); check("R7 enable other bits zero", d, 8'h04);
    wr(0, 1, 5'd1, 0, 32'h00);
    rd(0, 5'd1, d); check("R7 enable cleared", d, 8'h00);
    wr(0, 1, 5'd1, 0, 32'h04);
    rd(0, 5'd1, d); check("R7 enable set", d, 8'h04);
  endtask

  task automatic t_hot_add();
    logic [7:0] d;
    hot_add(8'd5);
    rd(1, 5'd0, d); check("R2 id5 byte0", d, 8'h20);
    rd(0, 5'd0, d); check("R4 status after new add", d, 8'h04);
    check("R5 sci with enable", sci, 1);
    hot_add(8'd255);
    rd(1, 5'd31, d); check("R2 id255 byte31", d, 8'h80);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(0, 1, 5'd0, 0, 32'hFB);
    rd(0, 5'd0, d); check("R6 write without bit2 keeps", d, 8'h04);
    wr(0, 1, 5'd0, 0, 32'h04);
    rd(0, 5'd0, d); check("R6 w1c clears", d, 8'h00);
    check("R5 sci after clear", sci, 0);
  endtask

  task automatic t_repeat();
    logic [7:0] d;
    hot_add(8'd5);
    rd(0, 5'd0, d); check("R4 repeat add no event", d, 8'h00);
    check("R4 sci stays low", sci, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(0, 1, 5'd1, 0, 32'h0);
    hot_add(8'd100);
    rd(0, 5'd0, d); check("R4 status id100", d, 8'h04);
    check("R5 sci masked", sci, 0);
    wr(0, 1, 5'd1, 0, 32'h4);
    check("R5 sci after enable", sci, 1);
    rd(1, 5'd12, d); check("R2 id100 byte12", d, 8'h10);
    wr(0, 1, 5'd0, 0, 32'h4);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    wr(1, 0, 5'd0, 1, 32'hFFFF_FFFF);
    wr(1, 0, 5'd12, 0, 32'h0000_0000);
    wr(1, 0, 5'd31, 1, 32'h0000_0000);
    rd(1, 5'd0, d);  check("R3 byte0 unchanged", d, 8'h20);
    rd(1, 5'd12, d); check("R3 byte12 unchanged", d, 8'h10);
    rd(1, 5'd31, d); check("R3 byte31 unchanged", d, 8'h80);
    check("R9 nonzero/other word no switch", new_if_sel, 0);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    wr(1, 0, 5'd0, 0, 32'h0);
    check("R9 byte write zero no switch", new_if_sel, 0);
    wr(1, 0, 5'd4, 1, 32'h0);
    check("R9 word1 zero no switch", new_if_sel, 0);
    wr(0, 1, 5'd0, 1, 32'h0);
    check("R9 gpe zero no switch", new_if_sel, 0);
    wr(1, 0, 5'd2, 1, 32'h0);
    check("R8 dword zero switches", new_if_sel, 1);
    wr(1, 0, 5'd0, 1, 32'h1234);
    repeat (3) @(negedge clk);
    check("R8 sticky", new_if_sel, 1);
    rd(1, 5'd0, d); check("R3 map intact after switch", d, 8'h20);
  endtask

  task automatic t_rd_hold();
    logic [7:0] d;
    rd(1, 5'd31, d);
    @(negedge clk); map_cs = 1; io_addr = 5'd0;
    @(negedge clk); idle();
    check("R10 data held without rd", io_rd_data, 8'h80);
    @(negedge clk); io_rd = 1;
    @(negedge clk); idle();
    check("R10 no select reads zero", io_rd_data, 8'h00);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    @(negedge clk);
    hp_add_valid = 1; hp_add_id = 8'd7;
    gpe_cs = 1; io_wr = 1; io_addr = 5'd0; io_wr_data = 32'h4;
    @(negedge clk); idle();
    rd(0, 5'd0, d); check("R6 set wins over clear", d, 8'h04);
  endtask

  task automatic t_reset_again();
    logic [7:0] d;
    do_reset();
    check("R1 mode cleared by reset", new_if_sel, 0);
    rd(1, 5'd0, d); check("R1 map cleared by reset", d, 8'h00);
  endtask

  initial begin
    rst_n = 0;
    idle();
    do_reset();
    t_reset();
    t_enable();
    t_hot_add();
    t_clear();
    t_repeat();
    t_disabled();
    t_readonly();
    t_mode();
    t_rd_hold();
    t_coincide();
    t_reset_again();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule